// File: doc/BRIEF.md
# Timer Channel Status Register

This block holds the status byte of one channel of a 16-bit up/down timer. It samples the counter value and the count direction on every clock. It raises an overflow flag when the count wraps upward from 0xFFFF to 0x0000. On some channels it also raises an underflow flag when the count wraps downward from 0x0000 to 0xFFFF. It also shows the direction the counter moved on the previous clock.

Software reads the byte through a combinational read port. A one-cycle `rd_en` pulse tells the block that software has taken the current value. A flag clears only when software writes 0 to it after an earlier read returned that flag as 1. Writing 1 to a flag does nothing.

The `CH` parameter sets the channel number, and the channel number decides which bits exist:
- Channel 0 has no direction bit.
- Only channels 1 and 2 have an underflow flag.
- Channel 4 also counts a 0x0001 to 0x0000 step in complementary-PWM mode as an overflow. An external acknowledge on channel 4 can clear its overflow flag.

Top module: `tmr_stat_reg`

## Requirements
- R1: After reset the overflow and underflow flags are 0 and the direction bit is 1, so `rdata` reads 0xC0 on every channel, and `ovf_req` is 0.
- R2: On channels 1 to 4, bit 7 of `rdata` is the value of `cnt_up` sampled at the last clock edge (1 = up, 0 = down). On channel 0, bit 7 always reads 1.
- R3: Bit 6 always reads 1 and bits 3..0 always read 0. Writes to these bits have no effect.
- R4: The overflow flag (bit 4) is set when `cnt` is 0xFFFF at one clock edge and 0x0000 at the next.
- R5: On channels 1 and 2, the underflow flag (bit 5) is set when `phase_mode` is high and `cnt` goes from 0x0000 at one edge to 0xFFFF at the next. On channels 0, 3 and 4, bit 5 always reads 0. Without `phase_mode` the flag is never set.
- R6: On channel 4 only, with `cpwm_mode` high, a step of `cnt` from 0x0001 to 0x0000 also sets the overflow flag.
- R7: A write with a 1 in bit 4 or bit 5 of `wdata` leaves that flag unchanged.
- R8: A write with a 0 in a flag's bit clears the flag only if a read pulse (`rd_en`) occurred while the flag was 1 and no write has happened since. Any write uses up that arming, whatever value it writes.
- R9: If a set condition and a valid clear fall in the same cycle, the flag stays 1.
- R10: On channel 4, `ack` high with `ack_keep` low clears the overflow flag. On other channels `ack` has no effect.
- R11: `ovf_req` always equals bit 4 of `rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt | input | CW | Current counter value |
| cnt_up | input | 1 | Count direction, 1 = up |
| phase_mode | input | 1 | Counter is in phase-counting mode |
| cpwm_mode | input | 1 | Counter is in complementary-PWM mode |
| rd_en | input | 1 | Software read strobe |
| wr_en | input | 1 | Software write strobe |
| wdata | input | 8 | Write data |
| ack | input | 1 | External overflow acknowledge |
| ack_keep | input | 1 | When high, `ack` does not clear the flag |
| rdata | output | 8 | Status byte |
| ovf_req | output | 1 | Overflow request, equal to the overflow flag |

## Verification
The bench writes 0 to a flag that was never read, and writes 0 again after an arming read has already been used up by a write of 1s. A design that clears on any 0 write, or that keeps its arming across writes, drops the flag too early in either case. It also lines up an overflow wrap with an armed clear in the same cycle; a design that lets the clear win loses that event. The channel variants are checked side by side:
- the underflow wrap with and without phase mode;
- the 1-to-0 step in complementary-PWM mode on channel 4 against channel 1;
- the acknowledge with and without its keep input;
- the reserved bits on channel 0.

A design that decodes these per channel wrongly shows a wrong bit 5, bit 7 or bit 4.

// File: rtl/tmr_stat_reg.sv
module tmr_stat_reg #(
  parameter int CH = 1,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cnt,
  input  logic          cnt_up,
  input  logic          phase_mode,
  input  logic          cpwm_mode,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic [7:0]    wdata,
  input  logic          ack,
  input  logic          ack_keep,
  output logic [7:0]    rdata,
  output logic          ovf_req
);
  localparam logic HAS_DIR  = (CH != 0);
  localparam logic HAS_UDF  = (CH == 1) || (CH == 2);
  localparam logic HAS_CH4  = (CH == 4);
  localparam logic [CW-1:0] TOP = {CW{1'b1}};
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] prev_q;
  logic dir_q, ovf_q, udf_q, arm_o, arm_u;

  always_ff @(posedge clk) prev_q <= cnt;

  wire ovf_evt = ((prev_q == TOP) && (cnt == '0)) ||
                 (HAS_CH4 && cpwm_mode && (prev_q == ONE) && (cnt == '0));
  wire udf_evt = HAS_UDF && phase_mode && (prev_q == '0) && (cnt == TOP);
  wire ovf_clr = (wr_en && !wdata[4] && arm_o) || (HAS_CH4 && ack && !ack_keep);
  wire udf_clr = wr_en && !wdata[5] && arm_u;
  wire unused_wbits = ^{wdata[7:6], wdata[3:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q <= 1'b1;
      ovf_q <= 1'b0;
      udf_q <= 1'b0;
      arm_o <= 1'b0;
      arm_u <= 1'b0;
    end else begin
      dir_q <= cnt_up;
      if (ovf_evt)      ovf_q <= 1'b1;
      else if (ovf_clr) ovf_q <= 1'b0;
      if (udf_evt)      udf_q <= 1'b1;
      else if (udf_clr) udf_q <= 1'b0;
      if (wr_en) begin
        arm_o <= 1'b0;
        arm_u <= 1'b0;
      end
      if (rd_en && ovf_q) arm_o <= 1'b1;
      if (rd_en && udf_q) arm_u <= 1'b1;
    end
  end

  assign rdata   = {(HAS_DIR ? dir_q : 1'b1), 1'b1, udf_q, ovf_q, 4'b0000};
  assign ovf_req = ovf_q;
endmodule

// File: rtl/tmr_stat_chk.sv
module tmr_stat_chk #(
  parameter int CH = 1,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] cnt,
  input logic          cnt_up,
  input logic          cpwm_mode,
  input logic          wr_en,
  input logic [7:0]    wdata,
  input logic          ack,
  input logic          ack_keep,
  input logic [7:0]    rdata,
  input logic          ovf_req
);
  localparam logic [CW-1:0] TOP = {CW{1'b1}};
  localparam logic [CW-1:0] ONE = CW'(1);
  localparam logic ACK_ON = (CH == 4);

  p_fixed_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[6] && (rdata[3:0] == 4'b0000));

  p_dir_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (rdata[7] == ((CH == 0) ? 1'b1 : $past(cnt_up))));

  p_ovf_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(cnt) == TOP) && (cnt == '0)) |=> rdata[4]);

  p_write_one_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata[4] && wr_en && wdata[4] && !(ACK_ON && ack && !ack_keep)) |=> rdata[4]);

  p_req_mirror_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_req == rdata[4]);

  generate
    if (CH != 1 && CH != 2) begin : g_no_udf
      p_no_udf_r5: assert property (@(posedge clk) disable iff (!rst_n) !rdata[5]);
    end
    if (CH == 4) begin : g_ch4
      p_cpwm_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cpwm_mode && ($past(cnt) == ONE) && (cnt == '0)) |=> rdata[4]);
      p_ack_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !ack_keep && (cnt != '0)) |=> !rdata[4]);
    end
  endgenerate
endmodule

bind tmr_stat_reg tmr_stat_chk #(.CH(CH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt(cnt), .cnt_up(cnt_up), .cpwm_mode(cpwm_mode),
  .wr_en(wr_en), .wdata(wdata), .ack(ack), .ack_keep(ack_keep),
  .rdata(rdata), .ovf_req(ovf_req)
);

// File: tb/tb_tmr_stat_reg.sv
module tb_tmr_stat_reg;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] cnt = 16'h0100;
  logic cnt_up = 1'b1, phase_mode = 1'b0, cpwm_mode = 1'b0;
  logic rd_en = 1'b0, wr_en = 1'b0, ack = 1'b0, ack_keep = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rd1, rd0, rd4;
  logic rq1, rq0, rq4;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tmr_stat_reg #(.CH(1)) dut (.clk, .rst_n, .cnt, .cnt_up, .phase_mode, .cpwm_mode,
    .rd_en, .wr_en, .wdata, .ack, .ack_keep, .rdata(rd1), .ovf_req(rq1));
  tmr_stat_reg #(.CH(0)) dut_c0 (.clk, .rst_n, .cnt, .cnt_up, .phase_mode, .cpwm_mode,
    .rd_en, .wr_en, .wdata, .ack, .ack_keep, .rdata(rd0), .ovf_req(rq0));
  tmr_stat_reg #(.CH(4)) dut_c4 (.clk, .rst_n, .cnt, .cnt_up, .phase_mode, .cpwm_mode,
    .rd_en, .wr_en, .wdata, .ack, .ack_keep, .rdata(rd4), .ovf_req(rq4));

  // cnt[36:21] up[20] phase[19] cpwm[18] rd[17] wr[16] wdata[15:8] expected[7:0]
  localparam int NV = 21;
  localparam logic [36:0] VEC [NV] = '{
    {16'h0100, 5'b10000, 8'h00, 8'hC0},  // R4 idle
    {16'hFFFF, 5'b10000, 8'h00, 8'hC0},
    {16'h0000, 5'b10000, 8'h00, 8'hD0},  // R4 wrap
    {16'h0001, 5'b10001, 8'h00, 8'hD0},  // R8 no arm
    {16'h0002, 5'b10010, 8'h00, 8'hD0},  // arm
    {16'h0003, 5'b10001, 8'hFF, 8'hD0},  // R7 write ones
    {16'h0004, 5'b10001, 8'h00, 8'hD0},  // R8 arm used
    {16'h0005, 5'b10010, 8'h00, 8'hD0},
    {16'h0006, 5'b10001, 8'hEF, 8'hC0},  // R8 clear
    {16'h0004, 5'b00000, 8'h00, 8'h40},  // R2 down
    {16'h0000, 5'b01000, 8'h00, 8'h40},
    {16'hFFFF, 5'b01000, 8'h00, 8'h60},  // R5 underflow
    {16'hFFFE, 5'b00010, 8'h00, 8'h60},
    {16'hFFFD, 5'b00001, 8'hDF, 8'h40},  // R8 clear udf
    {16'h0000, 5'b00000, 8'h00, 8'h40},
    {16'hFFFF, 5'b00000, 8'h00, 8'h40},  // R5 no phase mode
    {16'h0000, 5'b10000, 8'h00, 8'hD0},
    {16'hFFFF, 5'b10010, 8'h00, 8'hD0},
    {16'h0000, 5'b10001, 8'h00, 8'hD0},  // R9 set wins
    {16'h0001, 5'b10010, 8'h00, 8'hD0},
    {16'h0002, 5'b10001, 8'h00, 8'hC0}
  };

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    chk("R11", {7'd0, rq1}, {7'd0, rd1[4]});
    chk("R11", {7'd0, rq4}, {7'd0, rd4[4]});
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    chk("R1", rd1, 8'hC0); chk("R1", rd0, 8'hC0); chk("R1", rd4, 8'hC0);
    chk("R1", {7'd0, rq1}, 8'h00);
    for (int i = 0; i < NV; i++) begin
      {cnt, cnt_up, phase_mode, cpwm_mode, rd_en, wr_en, wdata} = VEC[i][36:8];
      step();
      chk($sformatf("R4/R5/R7/R8/R9 vector %0d", i), rd1, VEC[i][7:0]);
    end
    {cnt, cnt_up, phase_mode, cpwm_mode, rd_en, wr_en, wdata} = '0;
    cnt = 16'h0100; cnt_up = 1'b1; rst_n = 1'b0;
    step(); step();
    rst_n = 1'b1;
    chk("R1", rd4, 8'hC0);
    cnt = 16'hFFFF; step();
    cnt = 16'h0000; step();
    chk("R4", rd0, 8'hD0); chk("R4", rd4, 8'hD0);
    cnt = 16'hFFFF; cnt_up = 1'b0; phase_mode = 1'b1; step();
    chk("R2 ch0 bit7", rd0, 8'hD0);
    chk("R5 ch1", rd1, 8'h70); chk("R5 ch4", rd4, 8'h50);
    phase_mode = 1'b0; cnt = 16'h0001; ack = 1'b1; ack_keep = 1'b1; step();
    chk("R10 keep", rd4, 8'h50);
    cnt = 16'h0002; ack_keep = 1'b0; step();
    chk("R10 ch4 clear", rd4, 8'h40);
    chk("R10 ch1 ignore", rd1, 8'h70);
    chk("R10 ch0 ignore", rd0, 8'hD0);
    ack = 1'b0; cnt = 16'h0001; step();
    cnt = 16'h0000; cpwm_mode = 1'b1; step();
    chk("R6 ch4", rd4, 8'h50);
    chk("R6 ch1", rd1, 8'h70);
    cpwm_mode = 1'b0; wr_en = 1'b1; wdata = 8'h00; step();
    chk("R3", rd0, 8'hD0);
    wr_en = 1'b0;
    done = 1'b1;
    summary();
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end
endmodule